// File: doc/BRIEF.md
# Register Bus Diagnostic and Buffer Exercise Unit

This block sits at the bottom of a 32-bit memory-mapped register space and helps software confirm that its register, interrupt and memory paths work. It holds guard words that catch stray accesses. It has a 32-bit and a 64-bit scratch register that return double the value last written. It has a register that raises an interrupt for whatever vector software writes into it. It also has a small buffer engine. Given a byte address and a length, the engine zeroes, fills or inverts that byte range in an attached byte-wide memory.

Accesses are one 32-bit word at a time. A read request returns its data on the next cycle, with `reg_rvalid` set. The low two address bits must be zero for every mapped register. The guard range accepts any alignment. A 64-bit register is reached as two words, the lower word at the lower offset. The attached memory is a simple synchronous byte port: read data appears one cycle after the request. Interrupts leave the block as a one-cycle pulse that carries a vector number.

Top module: `regbus_diag_unit`

## Requirements
- R1: Any read at byte offsets 0x00 through 0x0F returns 0xDEADBABE. Writes to that range change nothing.
- R2: A read of the 32-bit scratch word at 0x10 returns twice the last value written, modulo 2^32. After reset it returns 0.
- R3: The 64-bit scratch register is written as a lower word at 0x18 and an upper word at 0x1C. Reading those two words returns the low and high halves of twice the 64-bit value, modulo 2^64, so bit 31 of the lower word carries into the upper word.
- R4: A write to 0x20 produces exactly one `irq_fire` pulse whose `irq_vec` equals the low VEC_W bits of the written data. The pulse appears in the cycle after the write is sampled. A read of 0x20 returns the stored vector.
- R5: Writing the value 1 to the operation word at 0x34 sets every byte of the range to 0x00. The range starts at the address held in 0x28/0x2C and is as long as the byte count at 0x30.
- R6: Writing the value 2 to the operation word sets every byte of the range to 0x96.
- R7: Writing the value 4 to the operation word replaces every byte of the range with its bitwise complement.
- R8: The range may start at any byte address and may cross a 256-byte boundary. Every byte in the range is processed, bytes are processed in ascending address order, and no byte outside the range is written.
- R9: Each accepted operation ends with exactly one `irq_fire` pulse carrying vector COMP_VEC (default 2).
- R10: An operation value other than exactly 1, 2 or 4 starts nothing. It writes no memory and raises no interrupt.
- R11: A write to the operation word while an operation is running is ignored. The running operation completes unchanged, and the operation word reads back the opcode that was accepted.
- R12: An operation with a byte count of zero touches no memory but still raises its completion interrupt. The memory port is idle whenever no operation runs.
- R13: Reads of unmapped offsets (for example 0x24, 0x38 and above, or a misaligned offset in 0x10 to 0x37) return 0. Writes to those offsets change nothing.
- R14: A completion and a vector write can fall in the same cycle. In that case the completion vector is issued first, and the written vector follows in the very next cycle. Neither is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Byte offset of the access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid one cycle after the read strobe |
| reg_rvalid | output | 1 | Marks the cycle that carries read data |
| mem_en | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write when set, read when clear |
| mem_addr | output | MEM_AW | Memory byte address |
| mem_wdata | output | 8 | Memory write byte |
| mem_rdata | input | 8 | Memory read byte, one cycle after a read request |
| irq_fire | output | 1 | One-cycle interrupt pulse |
| irq_vec | output | VEC_W | Vector number of the pulse |

## Verification
The completion interrupt of the buffer engine and the software-written test vector share a single pulse output, so both can ask for it in the same cycle. The bench provokes this directly. It starts a fill of known length, counts the cycles the engine needs, and lands the vector write on the exact edge where completion is reported. It then judges the outcome from the recorded pulses: the completion vector must come first, the written vector must follow exactly one cycle later, and each must appear exactly once. Around that case, near-exhaustive sweeps cover every opcode over every start offset and every short length across a 256-byte boundary, and every memory byte is compared against an arithmetic model.

// File: rtl/diag_pkg.sv
package diag_pkg;

   // Word returned for any access in the guard window
   localparam logic [31:0] GUARD_PATTERN = 32'hDEADBABE;
   // Byte pattern written by the fill operation
   localparam logic [7:0]  FILL_PATTERN  = 8'h96;

   // Byte offsets of mapped words (all word aligned)
   localparam logic [7:0] OFS_SCRATCH32 = 8'h10;
   localparam logic [7:0] OFS_SCR64_LO  = 8'h18;
   localparam logic [7:0] OFS_SCR64_HI  = 8'h1C;
   localparam logic [7:0] OFS_IRQ_TEST  = 8'h20;
   localparam logic [7:0] OFS_BUF_LO    = 8'h28;
   localparam logic [7:0] OFS_BUF_HI    = 8'h2C;
   localparam logic [7:0] OFS_BUF_LEN   = 8'h30;
   localparam logic [7:0] OFS_BUF_OP    = 8'h34;

   typedef enum logic [2:0] {
      OP_NONE   = 3'd0,
      OP_CLEAR  = 3'd1,
      OP_FILL   = 3'd2,
      OP_INVERT = 3'd4
   } buf_op_e;

   typedef enum logic [1:0] {
      ENG_IDLE,
      ENG_READ,
      ENG_WRITE
   } eng_state_e;

endpackage

// File: rtl/diag_regfile.sv
module diag_regfile
   import diag_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int VEC_W  = 8,
   parameter int MEM_AW = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   output logic              reg_rvalid,
   input  logic              eng_busy,
   output logic              start_o,
   output buf_op_e           start_op_o,
   output logic [MEM_AW-1:0] buf_base_o,
   output logic [31:0]       buf_len_o,
   output logic              sw_irq_o,
   output logic [VEC_W-1:0]  sw_vec_o
);

   logic       in_page;
   logic [7:0] ofs;

   // Offsets above the low 256 bytes are never mapped
   generate
      if (ADDR_W > 8) begin : g_wide
         assign in_page = ~|reg_addr[ADDR_W-1:8];
      end else begin : g_narrow
         assign in_page = 1'b1;
      end
   endgenerate

   assign ofs = reg_addr[7:0];

   logic guard_hit, hit_s32, hit_lo64, hit_hi64, hit_irq;
   logic hit_blo, hit_bhi, hit_len, hit_op;

   always_comb begin
      guard_hit = in_page && (ofs[7:4] == 4'h0);
      hit_s32   = in_page && (ofs == OFS_SCRATCH32);
      hit_lo64  = in_page && (ofs == OFS_SCR64_LO);
      hit_hi64  = in_page && (ofs == OFS_SCR64_HI);
      hit_irq   = in_page && (ofs == OFS_IRQ_TEST);
      hit_blo   = in_page && (ofs == OFS_BUF_LO);
      hit_bhi   = in_page && (ofs == OFS_BUF_HI);
      hit_len   = in_page && (ofs == OFS_BUF_LEN);
      hit_op    = in_page && (ofs == OFS_BUF_OP);
   end

   logic [31:0]      s32_q, s64_lo_q, s64_hi_q, blo_q, bhi_q, len_q;
   logic [VEC_W-1:0] vec_q;
   buf_op_e          op_q;
   logic             op_legal;
   logic [63:0]      dbl64;

   assign op_legal = (reg_wdata == 32'd1) || (reg_wdata == 32'd2) ||
                     (reg_wdata == 32'd4);

   assign start_o    = reg_wr && hit_op && op_legal && !eng_busy;
   assign start_op_o = buf_op_e'(reg_wdata[2:0]);
   assign sw_irq_o   = reg_wr && hit_irq;
   assign sw_vec_o   = reg_wdata[VEC_W-1:0];
   assign buf_base_o = blo_q[MEM_AW-1:0];
   assign buf_len_o  = len_q;
   assign dbl64      = {s64_hi_q, s64_lo_q} << 1;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         s32_q    <= '0;
         s64_lo_q <= '0;
         s64_hi_q <= '0;
         blo_q    <= '0;
         bhi_q    <= '0;
         len_q    <= '0;
         vec_q    <= '0;
         op_q     <= OP_NONE;
      end else begin
         if (reg_wr && hit_s32)  s32_q    <= reg_wdata;
         if (reg_wr && hit_lo64) s64_lo_q <= reg_wdata;
         if (reg_wr && hit_hi64) s64_hi_q <= reg_wdata;
         if (reg_wr && hit_blo)  blo_q    <= reg_wdata;
         if (reg_wr && hit_bhi)  bhi_q    <= reg_wdata;
         if (reg_wr && hit_len)  len_q    <= reg_wdata;
         if (sw_irq_o)           vec_q    <= sw_vec_o;
         if (start_o)            op_q     <= start_op_o;
      end
   end

   logic [31:0] rd_val;

   always_comb begin
      rd_val = '0;
      if (guard_hit)     rd_val = GUARD_PATTERN;
      else if (hit_s32)  rd_val = s32_q << 1;
      else if (hit_lo64) rd_val = dbl64[31:0];
      else if (hit_hi64) rd_val = dbl64[63:32];
      else if (hit_irq)  rd_val = 32'(vec_q);
      else if (hit_blo)  rd_val = blo_q;
      else if (hit_bhi)  rd_val = bhi_q;
      else if (hit_len)  rd_val = len_q;
      else if (hit_op)   rd_val = 32'(op_q);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         reg_rdata  <= '0;
         reg_rvalid <= 1'b0;
      end else begin
         reg_rvalid <= reg_rd;
         reg_rdata  <= reg_rd ? rd_val : '0;
      end
   end

endmodule

// File: rtl/diag_buf_engine.sv
module diag_buf_engine
   import diag_pkg::*;
#(
   parameter int MEM_AW = 10,
   parameter int LEN_W  = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  buf_op_e           op_i,
   input  logic [MEM_AW-1:0] base_i,
   input  logic [LEN_W-1:0]  len_i,
   output logic              busy_o,
   output logic              done_o,
   output buf_op_e           op_o,
   output logic              mem_en,
   output logic              mem_we,
   output logic [MEM_AW-1:0] mem_addr,
   output logic [7:0]        mem_wdata,
   input  logic [7:0]        mem_rdata
);

   localparam logic [LEN_W-1:0]  LAST_ONE = LEN_W'(1);
   localparam logic [MEM_AW-1:0] ADDR_INC = MEM_AW'(1);

   eng_state_e        state_q;
   buf_op_e           op_q;
   logic [MEM_AW-1:0] cur_q;
   logic [LEN_W-1:0]  left_q;
   logic              done_q;
   eng_state_e        after_write;

   // Inversion needs a read before each write; the others write straight
   assign after_write = (op_q == OP_INVERT) ? ENG_READ : ENG_WRITE;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ENG_IDLE;
         op_q    <= OP_NONE;
         cur_q   <= '0;
         left_q  <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (state_q)
            ENG_IDLE: begin
               if (start_i) begin
                  op_q   <= op_i;
                  cur_q  <= base_i;
                  left_q <= len_i;
                  if (len_i == '0) begin
                     done_q <= 1'b1;
                  end else begin
                     state_q <= (op_i == OP_INVERT) ? ENG_READ : ENG_WRITE;
                  end
               end
            end
            ENG_READ: state_q <= ENG_WRITE;
            ENG_WRITE: begin
               if (left_q == LAST_ONE) begin
                  state_q <= ENG_IDLE;
                  done_q  <= 1'b1;
               end else begin
                  left_q  <= left_q - LAST_ONE;
                  cur_q   <= cur_q + ADDR_INC;
                  state_q <= after_write;
               end
            end
            default: state_q <= ENG_IDLE;
         endcase
      end
   end

   always_comb begin
      case (op_q)
         OP_FILL:   mem_wdata = FILL_PATTERN;
         OP_INVERT: mem_wdata = ~mem_rdata;
         default:   mem_wdata = 8'h00;
      endcase
   end

   assign mem_en   = (state_q != ENG_IDLE);
   assign mem_we   = (state_q == ENG_WRITE);
   assign mem_addr = cur_q;
   assign busy_o   = (state_q != ENG_IDLE);
   assign done_o   = done_q;
   assign op_o     = op_q;

endmodule

// File: rtl/diag_irq_merge.sv
module diag_irq_merge #(
   parameter int VEC_W    = 8,
   parameter int COMP_VEC = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sw_req_i,
   input  logic [VEC_W-1:0] sw_vec_i,
   input  logic             done_i,
   output logic             irq_fire,
   output logic [VEC_W-1:0] irq_vec
);

   localparam logic [VEC_W-1:0] COMP_CODE = VEC_W'(COMP_VEC);

   logic             pend_q;
   logic [VEC_W-1:0] pend_vec_q;

   // Completion wins a shared cycle; the software vector waits one slot
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         irq_fire   <= 1'b0;
         irq_vec    <= '0;
         pend_q     <= 1'b0;
         pend_vec_q <= '0;
      end else begin
         irq_fire <= 1'b0;
         if (done_i) begin
            irq_fire <= 1'b1;
            irq_vec  <= COMP_CODE;
            if (sw_req_i) begin
               pend_q     <= 1'b1;
               pend_vec_q <= sw_vec_i;
            end
         end else if (pend_q) begin
            irq_fire <= 1'b1;
            irq_vec  <= pend_vec_q;
            if (sw_req_i) pend_vec_q <= sw_vec_i;
            else          pend_q     <= 1'b0;
         end else if (sw_req_i) begin
            irq_fire <= 1'b1;
            irq_vec  <= sw_vec_i;
         end
      end
   end

endmodule

// File: rtl/regbus_diag_unit.sv
module regbus_diag_unit
   import diag_pkg::*;
#(
   parameter int ADDR_W   = 16,
   parameter int MEM_AW   = 10,
   parameter int VEC_W    = 8,
   parameter int COMP_VEC = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   output logic              reg_rvalid,
   output logic              mem_en,
   output logic              mem_we,
   output logic [MEM_AW-1:0] mem_addr,
   output logic [7:0]        mem_wdata,
   input  logic [7:0]        mem_rdata,
   output logic              irq_fire,
   output logic [VEC_W-1:0]  irq_vec
);

   localparam int LEN_W = 32;

   generate
      if (ADDR_W < 8 || ADDR_W > 32) begin : g_bad_addr_w
         $error("ADDR_W must lie in 8..32");
      end
      if (MEM_AW < 1 || MEM_AW > 32) begin : g_bad_mem_aw
         $error("MEM_AW must lie in 1..32");
      end
      if (VEC_W < 2 || VEC_W > 32) begin : g_bad_vec_w
         $error("VEC_W must lie in 2..32");
      end
      if (COMP_VEC < 0 || COMP_VEC >= (1 << VEC_W)) begin : g_bad_comp
         $error("COMP_VEC must fit in VEC_W bits");
      end
   endgenerate

   logic              eng_busy, eng_done, eng_start, sw_irq;
   buf_op_e           start_op, eng_op;
   logic [MEM_AW-1:0] buf_base;
   logic [LEN_W-1:0]  buf_len;
   logic [VEC_W-1:0]  sw_vec;

   diag_regfile #(
      .ADDR_W (ADDR_W),
      .VEC_W  (VEC_W),
      .MEM_AW (MEM_AW)
   ) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .reg_wr     (reg_wr),
      .reg_rd     (reg_rd),
      .reg_addr   (reg_addr),
      .reg_wdata  (reg_wdata),
      .reg_rdata  (reg_rdata),
      .reg_rvalid (reg_rvalid),
      .eng_busy   (eng_busy),
      .start_o    (eng_start),
      .start_op_o (start_op),
      .buf_base_o (buf_base),
      .buf_len_o  (buf_len),
      .sw_irq_o   (sw_irq),
      .sw_vec_o   (sw_vec)
   );

   diag_buf_engine #(
      .MEM_AW (MEM_AW),
      .LEN_W  (LEN_W)
   ) u_eng (
      .clk       (clk),
      .rst_n     (rst_n),
      .start_i   (eng_start),
      .op_i      (start_op),
      .base_i    (buf_base),
      .len_i     (buf_len),
      .busy_o    (eng_busy),
      .done_o    (eng_done),
      .op_o      (eng_op),
      .mem_en    (mem_en),
      .mem_we    (mem_we),
      .mem_addr  (mem_addr),
      .mem_wdata (mem_wdata),
      .mem_rdata (mem_rdata)
   );

   diag_irq_merge #(
      .VEC_W    (VEC_W),
      .COMP_VEC (COMP_VEC)
   ) u_irq (
      .clk      (clk),
      .rst_n    (rst_n),
      .sw_req_i (sw_irq),
      .sw_vec_i (sw_vec),
      .done_i   (eng_done),
      .irq_fire (irq_fire),
      .irq_vec  (irq_vec)
   );

endmodule

// File: rtl/diag_unit_chk.sv
module diag_unit_chk
   import diag_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int MEM_AW = 10
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_rd,
   input logic [ADDR_W-1:0] reg_addr,
   input logic [31:0]       reg_rdata,
   input logic              reg_rvalid,
   input logic              mem_en,
   input logic              mem_we,
   input logic [MEM_AW-1:0] mem_addr,
   input logic [7:0]        mem_wdata,
   input logic              eng_busy,
   input buf_op_e           eng_op
);

   logic guard_rd, unmapped_rd;

   always_comb begin
      guard_rd    = reg_rd && (reg_addr < ADDR_W'(16));
      unmapped_rd = reg_rd && ((reg_addr >= ADDR_W'('h38)) ||
                               (reg_addr == ADDR_W'('h24)));
   end

   AST_GUARD_WORD: assert property (@(posedge clk) disable iff (!rst_n)
      guard_rd |=> reg_rvalid && (reg_rdata == 32'hDEADBABE)); // R1

   AST_SCRATCH32_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd && reg_addr == ADDR_W'('h10)) |=> (reg_rdata[0] == 1'b0)); // R2

   AST_SCRATCH64_LO_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd && reg_addr == ADDR_W'('h18)) |=> (reg_rdata[0] == 1'b0)); // R3

   AST_CLEAR_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && eng_op == OP_CLEAR) |-> (mem_wdata == 8'h00)); // R5

   AST_FILL_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && eng_op == OP_FILL) |-> (mem_wdata == 8'h96)); // R6

   AST_ASCENDING_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && $past(mem_we) && eng_op != OP_INVERT)
         |-> (mem_addr == $past(mem_addr) + MEM_AW'(1))); // R8

   AST_IDLE_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
      !eng_busy |-> !mem_en); // R12

   AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      unmapped_rd |=> (reg_rdata == 32'h0)); // R13

endmodule

bind regbus_diag_unit diag_unit_chk #(
   .ADDR_W (ADDR_W),
   .MEM_AW (MEM_AW)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .reg_rd     (reg_rd),
   .reg_addr   (reg_addr),
   .reg_rdata  (reg_rdata),
   .reg_rvalid (reg_rvalid),
   .mem_en     (mem_en),
   .mem_we     (mem_we),
   .mem_addr   (mem_addr),
   .mem_wdata  (mem_wdata),
   .eng_busy   (eng_busy),
   .eng_op     (eng_op)
);

// File: tb/regbus_diag_unit_tb.sv
module regbus_diag_unit_tb;

   localparam int ADDR_W = 16;
   localparam int MEM_AW = 10;
   localparam int VEC_W  = 8;
   localparam int MSIZE  = 1 << MEM_AW;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              reg_wr = 1'b0, reg_rd = 1'b0;
   logic [ADDR_W-1:0] reg_addr = '0;
   logic [31:0]       reg_wdata = '0;
   logic [31:0]       reg_rdata;
   logic              reg_rvalid;
   logic              mem_en, mem_we;
   logic [MEM_AW-1:0] mem_addr;
   logic [7:0]        mem_wdata;
   logic [7:0]        mem_rdata;
   logic              irq_fire;
   logic [VEC_W-1:0]  irq_vec;

   always #4 clk = ~clk;

   regbus_diag_unit #(
      .ADDR_W (ADDR_W), .MEM_AW (MEM_AW), .VEC_W (VEC_W), .COMP_VEC (2)
   ) u_dut (
      .clk (clk), .rst_n (rst_n), .reg_wr (reg_wr), .reg_rd (reg_rd),
      .reg_addr (reg_addr), .reg_wdata (reg_wdata), .reg_rdata (reg_rdata),
      .reg_rvalid (reg_rvalid), .mem_en (mem_en), .mem_we (mem_we),
      .mem_addr (mem_addr), .mem_wdata (mem_wdata), .mem_rdata (mem_rdata),
      .irq_fire (irq_fire), .irq_vec (irq_vec)
   );

   // Byte memory with a preload port used only by the bench
   logic [7:0] mem [0:MSIZE-1];
   logic [7:0] exp_mem [0:MSIZE-1];
   logic [7:0] mem_rd_q = '0;
   logic       ini_we = 1'b0;
   logic [MEM_AW-1:0] ini_a = '0;
   logic [7:0] ini_d = '0;
   int         mem_wr_cnt = 0;

   assign mem_rdata = mem_rd_q;

   always @(posedge clk) begin
      if (ini_we) mem[ini_a] <= ini_d;
      else if (mem_en) begin
         if (mem_we) begin
            mem[mem_addr] <= mem_wdata;
            mem_wr_cnt    <= mem_wr_cnt + 1;
         end else begin
            mem_rd_q <= mem[mem_addr];
         end
      end
   end

   // Interrupt monitor
   int          cyc = 0;
   int          comp_cnt = 0, sw_cnt = 0;
   int          last_comp_cyc = -10, last_sw_cyc = -10;
   logic [7:0]  last_sw_vec = '0;

   always @(negedge clk) begin
      if (rst_n && irq_fire) begin
         if (irq_vec == 8'd2) begin
            comp_cnt      = comp_cnt + 1;
            last_comp_cyc = cyc;
         end else begin
            sw_cnt      = sw_cnt + 1;
            last_sw_cyc = cyc;
            last_sw_vec = irq_vec;
         end
      end
   end

   int n_cmp = 0, n_bad = 0;
   bit finished = 1'b0;

   task automatic check(input string req, input logic [63:0] act,
                        input logic [63:0] expv);
      n_cmp++;
      if (act !== expv) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
      end
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc == 190000 && !finished) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog expired");
         finish_run();
      end
   end

   // All tasks are entered at a falling edge
   task automatic wr(input logic [15:0] a, input logic [31:0] d);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [15:0] a, output logic [31:0] d);
      reg_rd = 1'b1; reg_addr = a;
      @(negedge clk);
      reg_rd = 1'b0;
      d = reg_rdata;
   endtask

   function automatic logic [7:0] apply(input int op, input logic [7:0] b);
      case (op)
         1: return 8'h00;
         2: return 8'h96;
         4: return ~b;
         default: return b;
      endcase
   endfunction

   function automatic int window_bad(input int base, input int len);
      int bad = 0;
      for (int k = -4; k < len + 4; k++) begin
         int a = (base + k) & (MSIZE - 1);
         if (mem[a] !== exp_mem[a]) bad++;
      end
      return bad;
   endfunction

   task automatic run_op(input int base, input int len, input int op,
                         input string tag);
      int c0, w0;
      wr(16'h28, 32'(base));
      wr(16'h2C, 32'h0);
      wr(16'h30, 32'(len));
      c0 = comp_cnt;
      w0 = mem_wr_cnt;
      wr(16'h34, 32'(op));
      for (int t = 0; t < 300 && comp_cnt == c0; t++) @(negedge clk);
      repeat (3) @(negedge clk);
      check("R9 one completion", 64'(comp_cnt), 64'(c0 + 1));
      for (int k = 0; k < len; k++) begin
         int a = (base + k) & (MSIZE - 1);
         exp_mem[a] = apply(op, exp_mem[a]);
      end
      check(tag, 64'(window_bad(base, len)), 64'd0);
      if (len == 0) check("R12 zero length writes", 64'(mem_wr_cnt - w0), 64'd0);
   endtask

   initial begin
      logic [31:0] d;
      logic [63:0] v64, d64;
      int c0, s0, w0;

      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R4 reset irq idle", 64'(irq_fire), 64'd0);
      check("R12 reset mem idle", 64'(mem_en), 64'd0);
      rd(16'h10, d);
      check("R2 reset value", 64'(d), 64'd0);

      // Preload memory with a known pattern
      for (int i = 0; i < MSIZE; i++) begin
         ini_we = 1'b1; ini_a = MEM_AW'(i); ini_d = 8'(i * 37 + 11);
         exp_mem[i] = 8'(i * 37 + 11);
         @(negedge clk);
      end
      ini_we = 1'b0;
      @(negedge clk);

      // R1 guard window
      wr(16'h04, 32'h1234_5678);
      for (int a = 0; a < 16; a++) begin
         rd(16'(a), d);
         check("R1 guard read", 64'(d), 64'hDEADBABE);
      end

      // R2 doubling sweep
      for (int i = 0; i <= 32; i++) begin
         logic [31:0] v = (i == 32) ? 32'hFFFF_FFFF : (32'h1 << i) | 32'(i);
         wr(16'h10, v);
         rd(16'h10, d);
         check("R2 scratch32", 64'(d), 64'(v * 32'd2));
      end

      // R3 64-bit doubling with carry across words
      for (int i = 0; i < 4; i++) begin
         case (i)
            0: v64 = 64'h0000_0001_8000_0000;
            1: v64 = 64'h8000_0000_FFFF_FFFF;
            2: v64 = 64'h1234_5678_9ABC_DEF0;
            default: v64 = 64'hFFFF_FFFF_FFFF_FFFF;
         endcase
         d64 = v64 * 64'd2;
         wr(16'h18, v64[31:0]);
         wr(16'h1C, v64[63:32]);
         rd(16'h18, d);
         check("R3 low word", 64'(d), 64'(d64[31:0]));
         rd(16'h1C, d);
         check("R3 high word", 64'(d), 64'(d64[63:32]));
      end

      // R13 unmapped offsets
      wr(16'h10, 32'h0000_0021);
      wr(16'h24, 32'hFFFF_FFFF);
      wr(16'h40, 32'hFFFF_FFFF);
      wr(16'h11, 32'hFFFF_FFFF);
      rd(16'h24, d);   check("R13 hole 0x24", 64'(d), 64'd0);
      rd(16'h38, d);   check("R13 0x38", 64'(d), 64'd0);
      rd(16'h100, d);  check("R13 0x100", 64'(d), 64'd0);
      rd(16'h11, d);   check("R13 misaligned", 64'(d), 64'd0);
      rd(16'h10, d);   check("R13 no side effect", 64'(d), 64'h42);
      rd(16'h10, d);   check("R1 guard write ignored", 64'(d), 64'h42);

      // R4 software vector
      for (int i = 0; i < 3; i++) begin
         logic [31:0] v = (i == 0) ? 32'h37 : (i == 1) ? 32'hC5 : 32'h123;
         s0 = sw_cnt;
         wr(16'h20, v);
         repeat (3) @(negedge clk);
         check("R4 one pulse", 64'(sw_cnt), 64'(s0 + 1));
         check("R4 vector", 64'(last_sw_vec), 64'(v[7:0]));
         rd(16'h20, d);
         check("R4 readback", 64'(d), 64'(v[7:0]));
      end

      // R5 R6 R7 R8 sweep across a 256-byte boundary
      for (int oi = 0; oi < 3; oi++) begin
         int op = (oi == 0) ? 1 : (oi == 1) ? 2 : 4;
         string tag = (oi == 0) ? "R5 clear R8" : (oi == 1) ? "R6 fill R8" : "R7 invert R8";
         for (int off = 0; off < 10; off++)
            for (int len = 0; len < 18; len++)
               run_op(32'h1FA + off, len, op, tag);
      end

      // R10 illegal opcodes
      for (int i = 0; i < 4; i++) begin
         int bad_op = (i == 0) ? 3 : (i == 1) ? 0 : (i == 2) ? 8 : 32'h101;
         wr(16'h28, 32'h080);
         wr(16'h30, 32'd8);
         c0 = comp_cnt; w0 = mem_wr_cnt;
         wr(16'h34, 32'(bad_op));
         repeat (40) @(negedge clk);
         check("R10 no completion", 64'(comp_cnt), 64'(c0));
         check("R10 no memory write", 64'(mem_wr_cnt - w0), 64'd0);
         check("R10 memory unchanged", 64'(window_bad(32'h080, 8)), 64'd0);
      end

      // R12 zero length
      run_op(32'h2F0, 0, 2, "R12 zero length memory");

      // R11 write while busy
      wr(16'h28, 32'h100);
      wr(16'h30, 32'd20);
      c0 = comp_cnt;
      wr(16'h34, 32'd2);
      wr(16'h34, 32'd1);
      repeat (60) @(negedge clk);
      check("R11 single completion", 64'(comp_cnt), 64'(c0 + 1));
      for (int k = 0; k < 20; k++) exp_mem[32'h100 + k] = 8'h96;
      check("R11 busy write ignored", 64'(window_bad(32'h100, 20)), 64'd0);
      rd(16'h34, d);
      check("R11 accepted opcode", 64'(d), 64'd2);

      // R14 completion and vector write in the same cycle
      for (int n = 1; n <= 6; n += 5) begin
         wr(16'h28, 32'h300);
         wr(16'h30, 32'(n));
         c0 = comp_cnt; s0 = sw_cnt;
         wr(16'h34, 32'd2);
         repeat (n) @(negedge clk);
         wr(16'h20, 32'h5A);
         repeat (6) @(negedge clk);
         check("R14 completion kept", 64'(comp_cnt), 64'(c0 + 1));
         check("R14 vector kept", 64'(sw_cnt), 64'(s0 + 1));
         check("R14 order", 64'(last_sw_cyc - last_comp_cyc), 64'd1);
         check("R14 vector value", 64'(last_sw_vec), 64'h5A);
         for (int k = 0; k < n; k++) exp_mem[32'h300 + k] = 8'h96;
         check("R14 memory", 64'(window_bad(32'h300, n)), 64'd0);
      end

      finish_run();
   end

endmodule